// File: doc/BRIEF.md
# Card Clock Divider and Mode Control

This block derives the clock sent to a memory card from the kernel clock. A divider field sets the ratio. The card clock runs at the kernel rate divided by twice the divider value, so both halves of each period last the same number of kernel cycles. A divider of zero passes the kernel clock straight through, except in double-data-rate mode. In that mode straight-through is not allowed: the block raises an error flag and runs at half the kernel rate.

The data path gets several outputs from the block:
- the active lane mask for 1, 4 or 8 data lines,
- the double-data-rate and high-speed indicators,
- a one-cycle strobe on each card clock edge it must sample on,
- a receive clock, which is either the card clock or an external feedback clock.

When hardware flow control is on, the block parks the card clock low while the data FIFO cannot take or supply data. Divider and mode changes are only accepted at the start of a low phase, so the output never shows a shortened pulse. Every control pin is plain and level-based. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `cardclk_ctrl`

## Requirements
- R1: For a nonzero divider D, `cclk_o` stays high for exactly D kernel cycles and low for exactly D kernel cycles, a period of 2·D.
- R2: With divider 0 and DDR off, `cclk_o` follows the kernel clock and `stb_o` is held at 1.
- R3: With divider 0 and DDR on, the output is never the undivided clock. `cclk_o` runs at divide-by-two (1 cycle high, 1 cycle low) and `err_o` is 1. `err_o` is 0 for any nonzero divider.
- R4: A new divider value written during a high phase does not shorten that phase. It takes effect from the next low phase onward.
- R5: `width_i` sets `lane_mask_o`: code 0 gives 8'h01, code 1 gives 8'h0F, code 2 gives 8'hFF, and code 3 is treated as 8'h01.
- R6: In SDR mode `stb_o` pulses for one kernel cycle per card clock rising edge. In DDR mode it pulses on both the rising and falling edges.
- R7: With `flow_en_i`=1, `cclk_o` is held low when `rx_dir_i`=1 and `fifo_full_i`=1, or when `rx_dir_i`=0 and `fifo_empty_i`=1. The clock resumes when that condition clears. With `flow_en_i`=0 the FIFO flags have no effect. In receive mode `fifo_empty_i` has no effect, and in transmit mode `fifo_full_i` has no effect.
- R8: `rx_clk_o` equals `fb_clk_i` when `rx_fb_sel_i`=1 and equals `cclk_o` when `rx_fb_sel_i`=0.
- R9: `hs_o` reflects the bus-speed bit and `ddr_o` the DDR enable, both taken at the same point as the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fb_clk_i | input | 1 | External feedback clock for receive sampling |
| div_i | input | DIV_W | Divider field (0 = bypass) |
| width_i | input | 2 | Bus-width code |
| ddr_en_i | input | 1 | Double-data-rate enable |
| speed_i | input | 1 | High-speed sampling path select |
| rx_fb_sel_i | input | 1 | Receive clock source: 1 = feedback clock |
| flow_en_i | input | 1 | Hardware flow control enable |
| rx_dir_i | input | 1 | Transfer direction: 1 = receive, 0 = transmit |
| fifo_full_i | input | 1 | Data FIFO full |
| fifo_empty_i | input | 1 | Data FIFO empty |
| cclk_o | output | 1 | Card clock |
| rx_clk_o | output | 1 | Receive sampling clock |
| stb_o | output | 1 | Sampling strobe, one kernel cycle per active card clock edge |
| lane_mask_o | output | 8 | Active data lines |
| ddr_o | output | 1 | Active DDR mode |
| hs_o | output | 1 | Active high-speed mode |
| err_o | output | 1 | Zero divider requested with DDR enabled |

## Verification
The assertions assume that every control input and FIFO flag is synchronous to the kernel clock and stable around its rising edge. They also assume that `fb_clk_i` feeds only the receive clock mux. The stimulus changes inputs just after a clock edge. It holds each configuration for several card clock periods before measuring, so every comparison starts after a low-phase load point. Half-period lengths are measured as whole runs of samples taken at the falling kernel edge. The partial run seen when a measurement opens is discarded. Bypass output is sampled two nanoseconds into each kernel half-cycle.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;

  typedef enum logic [1:0] {
    BW_ONE   = 2'd0,
    BW_FOUR  = 2'd1,
    BW_EIGHT = 2'd2,
    BW_RSVD  = 2'd3
  } bus_width_e;

  typedef struct packed {
    logic [7:0] lanes;
    logic       ddr;
    logic       hs;
  } mode_t;

  localparam mode_t MODE_RESET = '{lanes: 8'h01, ddr: 1'b0, hs: 1'b0};

  function automatic logic [7:0] lane_mask(input logic [1:0] code);
    bus_width_e w;
    w = bus_width_e'(code);
    case (w)
      BW_FOUR:  lane_mask = 8'h0F;
      BW_EIGHT: lane_mask = 8'hFF;
      default:  lane_mask = 8'h01;
    endcase
  endfunction

endpackage

// File: rtl/cardclk_cfg.sv
module cardclk_cfg
  import cardclk_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic [1:0]       width_i,
  input  logic             ddr_en_i,
  input  logic             speed_i,
  output logic [DIV_W-1:0] eff_div_o,
  output logic             byp_req_o,
  output mode_t            mode_o,
  output logic             err_o
);

  localparam logic [DIV_W-1:0] DIV_ZERO = '0;
  localparam logic [DIV_W-1:0] DIV_HALF = DIV_W'(1);

  logic zero_div;
  logic err_q;

  assign zero_div = (div_i == DIV_ZERO);

  always_comb begin
    if (!zero_div) begin
      eff_div_o = div_i;
      byp_req_o = 1'b0;
    end else if (ddr_en_i) begin
      eff_div_o = DIV_HALF;
      byp_req_o = 1'b0;
    end else begin
      eff_div_o = DIV_ZERO;
      byp_req_o = 1'b1;
    end
    mode_o.lanes = lane_mask(width_i);
    mode_o.ddr   = ddr_en_i;
    mode_o.hs    = speed_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= zero_div & ddr_en_i;
  end

  assign err_o = err_q;

  assert_cfg_fallback_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byp_req_o |-> (eff_div_o == DIV_ZERO && !mode_o.ddr));

endmodule

// File: rtl/cardclk_gen.sv
module cardclk_gen
  import cardclk_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] eff_div_i,
  input  logic             byp_req_i,
  input  mode_t            mode_i,
  input  logic             stall_i,
  output logic             cclk_o,
  output logic             byp_o,
  output logic             stb_o,
  output mode_t            mode_o
);

  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_q;
  logic             cclk_q;
  logic             byp_q;
  logic             stb_q;
  mode_t            mode_q;
  logic             hold;
  logic             term;
  logic             load;

  assign hold = !cclk_q && stall_i;
  assign term = (cnt_q == div_q - ONE);
  assign load = byp_q || hold || (term && cclk_q);

  // phase counter and card clock level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      cclk_q <= 1'b0;
      stb_q  <= 1'b0;
    end else if (byp_q) begin
      cnt_q  <= '0;
      cclk_q <= 1'b0;
      stb_q  <= !stall_i;
    end else if (hold) begin
      cnt_q  <= '0;
      stb_q  <= 1'b0;
    end else if (term) begin
      cnt_q  <= '0;
      cclk_q <= !cclk_q;
      stb_q  <= !cclk_q || mode_q.ddr;
    end else begin
      cnt_q  <= cnt_q + ONE;
      stb_q  <= 1'b0;
    end
  end

  // shadow settings, taken only where the output is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= ONE;
      byp_q  <= 1'b0;
      mode_q <= MODE_RESET;
    end else if (load) begin
      div_q  <= eff_div_i;
      byp_q  <= byp_req_i;
      mode_q <= mode_i;
    end
  end

  assign cclk_o = cclk_q;
  assign byp_o  = byp_q;
  assign stb_o  = stb_q;
  assign mode_o = mode_q;

  assert_half_len_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cclk_q) |-> ($past(cnt_q) == $past(div_q) - ONE));

  assert_no_ddr_bypass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q.ddr |-> (!byp_q && div_q != '0));

  assert_load_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(div_q) |-> !cclk_q);

  assert_lane_code_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q.lanes inside {8'h01, 8'h0F, 8'hFF});

  assert_stall_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && !cclk_q) |=> !cclk_q);

  assert_bypass_parked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byp_q |=> !cclk_q);

endmodule

// File: rtl/cardclk_out.sv
module cardclk_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic byp_i,
  input  logic stall_i,
  input  logic div_clk_i,
  input  logic fb_clk_i,
  input  logic fb_sel_i,
  output logic cclk_o,
  output logic rx_clk_o
);

  logic pass_q;

  // enable changes only while the kernel clock is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pass_q <= 1'b0;
    else         pass_q <= byp_i && !stall_i;
  end

  assign cclk_o   = pass_q ? clk_i : div_clk_i;
  assign rx_clk_o = fb_sel_i ? fb_clk_i : cclk_o;

  assert_pass_needs_bypass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pass_q && !byp_i) |=> !pass_q);

endmodule

// File: rtl/cardclk_ctrl.sv
module cardclk_ctrl
  import cardclk_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fb_clk_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [1:0]       width_i,
  input  logic             ddr_en_i,
  input  logic             speed_i,
  input  logic             rx_fb_sel_i,
  input  logic             flow_en_i,
  input  logic             rx_dir_i,
  input  logic             fifo_full_i,
  input  logic             fifo_empty_i,
  output logic             cclk_o,
  output logic             rx_clk_o,
  output logic             stb_o,
  output logic [7:0]       lane_mask_o,
  output logic             ddr_o,
  output logic             hs_o,
  output logic             err_o
);

  logic [DIV_W-1:0] eff_div;
  logic             byp_req;
  mode_t            mode_next;
  mode_t            mode_act;
  logic             stall;
  logic             div_clk;
  logic             byp_act;

  assign stall = flow_en_i && (rx_dir_i ? fifo_full_i : fifo_empty_i);

  cardclk_cfg #(.DIV_W(DIV_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .div_i    (div_i),
    .width_i  (width_i),
    .ddr_en_i (ddr_en_i),
    .speed_i  (speed_i),
    .eff_div_o(eff_div),
    .byp_req_o(byp_req),
    .mode_o   (mode_next),
    .err_o    (err_o)
  );

  cardclk_gen #(.DIV_W(DIV_W)) u_gen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .eff_div_i(eff_div),
    .byp_req_i(byp_req),
    .mode_i   (mode_next),
    .stall_i  (stall),
    .cclk_o   (div_clk),
    .byp_o    (byp_act),
    .stb_o    (stb_o),
    .mode_o   (mode_act)
  );

  cardclk_out u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .byp_i    (byp_act),
    .stall_i  (stall),
    .div_clk_i(div_clk),
    .fb_clk_i (fb_clk_i),
    .fb_sel_i (rx_fb_sel_i),
    .cclk_o   (cclk_o),
    .rx_clk_o (rx_clk_o)
  );

  assign lane_mask_o = mode_act.lanes;
  assign ddr_o       = mode_act.ddr;
  assign hs_o        = mode_act.hs;

endmodule

// File: tb/cardclk_ctrl_tb.sv
module cardclk_ctrl_tb;

  localparam int DIV_W = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             fb_clk_i = 1'b0;
  logic [DIV_W-1:0] div_i = 8'd2;
  logic [1:0]       width_i = 2'd0;
  logic             ddr_en_i = 1'b0;
  logic             speed_i = 1'b0;
  logic             rx_fb_sel_i = 1'b0;
  logic             flow_en_i = 1'b0;
  logic             rx_dir_i = 1'b1;
  logic             fifo_full_i = 1'b0;
  logic             fifo_empty_i = 1'b0;
  logic             cclk_o, rx_clk_o, stb_o, ddr_o, hs_o, err_o;
  logic [7:0]       lane_mask_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  int exp_q[$];
  bit mon_en = 0;
  bit started = 0;
  bit skipping = 0;
  logic prev_lvl = 1'b0;
  int runlen = 0;

  always #5 clk_i = ~clk_i;

  cardclk_ctrl #(.DIV_W(DIV_W)) u_dut (
    .clk_i, .rst_ni, .fb_clk_i, .div_i, .width_i, .ddr_en_i, .speed_i,
    .rx_fb_sel_i, .flow_en_i, .rx_dir_i, .fifo_full_i, .fifo_empty_i,
    .cclk_o, .rx_clk_o, .stb_o, .lane_mask_o, .ddr_o, .hs_o, .err_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: completed half-period runs against the expected queue
  always @(negedge clk_i) begin
    if (!mon_en) begin
      started = 0;
    end else if (!started) begin
      started = 1;
      skipping = 1;
      prev_lvl = cclk_o;
      runlen = 1;
    end else if (cclk_o == prev_lvl) begin
      runlen++;
    end else begin
      if (skipping) skipping = 0;
      else if (exp_q.size() > 0) begin
        int e;
        e = exp_q.pop_front();
        chk(runlen == e, "R1 half-period length", runlen, e);
      end
      prev_lvl = cclk_o;
      runlen = 1;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  // driver: set divider, push expected run lengths, let monitor compare
  task automatic run_div(input int d, input bit ddr, input int eff);
    div_i = DIV_W'(d);
    ddr_en_i = ddr;
    step(40);
    for (int k = 0; k < 4; k++) exp_q.push_back(eff);
    mon_en = 1;
    step(6 * eff + 4);
    chk(exp_q.size() == 0, "R1 runs observed", exp_q.size(), 0);
    exp_q.delete();
    mon_en = 0;
    step(1);
  endtask

  task automatic count_ones(input int n, output int ones);
    ones = 0;
    repeat (n) begin
      @(negedge clk_i);
      if (cclk_o) ones++;
    end
    #1;
  endtask

  task automatic count_stb(input int n, output int cnt);
    cnt = 0;
    repeat (n) begin
      @(negedge clk_i);
      if (stb_o) cnt++;
    end
    #1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v, hl, ll;
    // reset state
    #22;
    chk(cclk_o == 1'b0, "reset cclk", cclk_o, 0);
    chk(stb_o == 1'b0, "reset stb", stb_o, 0);
    chk(err_o == 1'b0, "reset err", err_o, 0);
    chk(lane_mask_o == 8'h01, "reset lanes", lane_mask_o, 1);
    rst_ni = 1'b1;
    step(2);

    // R1: several dividers, equal halves
    run_div(1, 0, 1);
    run_div(3, 0, 3);
    run_div(5, 1, 5);
    run_div(8, 0, 8);
    chk(err_o == 1'b0, "R3 no error for nonzero divider", err_o, 0);

    // R3: zero divider with DDR falls back to divide-by-two
    run_div(0, 1, 1);
    chk(err_o == 1'b1, "R3 error flag", err_o, 1);
    chk(ddr_o == 1'b1, "R9 ddr active", ddr_o, 1);

    // R6: strobes, DDR then SDR, with D=3 over 6 periods
    div_i = 8'd3; ddr_en_i = 1'b1; step(40);
    count_stb(36, v);
    chk(v == 12, "R6 DDR strobes", v, 12);
    ddr_en_i = 1'b0; step(40);
    count_stb(36, v);
    chk(v == 6, "R6 SDR strobes", v, 6);
    chk(ddr_o == 1'b0, "R9 ddr inactive", ddr_o, 0);

    // R4: change divider during a high phase
    div_i = 8'd6; step(40);
    @(negedge clk_i);
    while (cclk_o !== 1'b0) @(negedge clk_i);
    while (cclk_o !== 1'b1) @(negedge clk_i);
    #1 div_i = 8'd2;
    hl = 1;
    @(negedge clk_i);
    while (cclk_o === 1'b1) begin hl++; @(negedge clk_i); end
    ll = 1;
    @(negedge clk_i);
    while (cclk_o === 1'b0) begin ll++; @(negedge clk_i); end
    chk(hl == 6, "R4 high phase keeps old length", hl, 6);
    chk(ll == 2, "R4 low phase uses new length", ll, 2);
    #1;

    // R2: bypass follows the kernel clock
    div_i = 8'd0; ddr_en_i = 1'b0; step(40);
    chk(err_o == 1'b0, "R3 no error in bypass", err_o, 0);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk_i); #2;
      chk(cclk_o == 1'b1, "R2 bypass high half", cclk_o, 1);
      @(negedge clk_i); #2;
      chk(cclk_o == 1'b0, "R2 bypass low half", cclk_o, 0);
      chk(stb_o == 1'b1, "R2 bypass strobe", stb_o, 1);
    end
    // R7: flow control in bypass (transmit, empty)
    flow_en_i = 1'b1; rx_dir_i = 1'b0; fifo_empty_i = 1'b1;
    step(3);
    @(posedge clk_i); #2;
    chk(cclk_o == 1'b0, "R7 bypass stopped", cclk_o, 0);
    flow_en_i = 1'b0; fifo_empty_i = 1'b0; rx_dir_i = 1'b1;

    // R7: flow control with divider 2
    div_i = 8'd2; step(20);
    flow_en_i = 1'b1; rx_dir_i = 1'b1; fifo_full_i = 1'b1; step(20);
    count_ones(12, v);
    chk(v == 0, "R7 receive full stops", v, 0);
    fifo_full_i = 1'b0; fifo_empty_i = 1'b1; step(10);
    count_ones(12, v);
    chk(v == 6, "R7 empty ignored on receive", v, 6);
    rx_dir_i = 1'b0; step(20);
    count_ones(12, v);
    chk(v == 0, "R7 transmit empty stops", v, 0);
    fifo_empty_i = 1'b0; fifo_full_i = 1'b1; step(10);
    count_ones(12, v);
    chk(v == 6, "R7 full ignored on transmit", v, 6);
    flow_en_i = 1'b0; fifo_empty_i = 1'b1; step(10);
    count_ones(12, v);
    chk(v == 6, "R7 flags ignored when disabled", v, 6);
    fifo_empty_i = 1'b0; fifo_full_i = 1'b0;

    // R8: receive clock source
    rx_fb_sel_i = 1'b1; fb_clk_i = 1'b1; #1;
    chk(rx_clk_o == 1'b1, "R8 feedback high", rx_clk_o, 1);
    fb_clk_i = 1'b0; #1;
    chk(rx_clk_o == 1'b0, "R8 feedback low", rx_clk_o, 0);
    rx_fb_sel_i = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      chk(rx_clk_o == cclk_o, "R8 internal source", rx_clk_o, cclk_o);
    end
    #1;

    // R5 / R9: lane decode and speed indicator
    for (int w = 0; w < 4; w++) begin
      logic [7:0] em;
      width_i = 2'(w);
      speed_i = w[0];
      step(20);
      em = (w == 1) ? 8'h0F : (w == 2) ? 8'hFF : 8'h01;
      chk(lane_mask_o == em, "R5 lane mask", lane_mask_o, em);
      chk(hs_o == w[0], "R9 speed indicator", hs_o, w[0]);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule